// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This controller gathers a set of level-sensitive interrupt request lines, one per numeric priority level, and presents a single interrupt to a processor. The chosen level is held on the interrupt output until the processor acknowledges it. At acknowledge, the controller forms the handler address from a programmable table base, adding four bytes per level, and holds that address for the processor to fetch.

The controller tracks which levels are in service, so handlers can nest. While a level is being serviced, that level and every level numbered above it are masked. Only a request with a strictly lower number can interrupt the running handler. When a handler finishes, software pulses the end-of-service strobe. This retires the level that was accepted most recently and restores the masking that applied before it.

Saving processor state is left to the processor. The table base is loaded through a one-word write port.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the vector address is zero, the table base is zero and no level is in service.
- R2: If no interrupt is being presented and an eligible request line is high at a clock edge, the interrupt output is high from that edge on. The level presented is the highest-numbered eligible request. A request line at index k has level k.
- R3: Once high, the interrupt output stays high until a clock edge with the acknowledge input high, even if the request line drops.
- R4: At an edge where acknowledge is high while the interrupt output is high, the vector address becomes base + 4 × (presented level) and the interrupt output goes low. The vector address keeps that value until the next such acknowledge.
- R5: While any level is in service, let L be the lowest-numbered level in service. Requests at level L or above are ignored: they never raise the interrupt output. Requests below L are eligible. With nothing in service, every level is eligible.
- R6: An end-of-service pulse at an edge retires the most recently accepted level. Under R5 this is always the lowest-numbered level in service. From the next edge on, masking follows the levels that remain.
- R7: A base write at an edge loads the table base for acknowledges at later edges. It does not change the vector address already presented. An acknowledge at the same edge uses the old base.
- R8: An acknowledge while the interrupt output is low has no effect on the vector address. An end-of-service pulse with nothing in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NLVL | Level-sensitive requests, bit k is level k |
| cpu_irq | output | 1 | Interrupt to the processor |
| cpu_ack | input | 1 | Processor acknowledge |
| vec_addr | output | AW | Handler address latched at acknowledge |
| eoi | input | 1 | End-of-service pulse from software |
| base_we | input | 1 | Table base write enable |
| base_wdata | input | AW | Table base write data |

## Verification
The hardest situation to reach from the ports is a stack of three nested handlers unwinding one level at a time. A mid-priority request must stay masked after the first end-of-service, because a lower level is still active, and then win after the second. Directed steps build the stack 9, 4, 3. They retire it while holding request 5 high, and check the interrupt output after each retirement. A long random run then mixes sparse request patterns with acknowledges, end-of-service pulses and base writes. Each cycle is compared against a bench model of the masking and vector rules.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NLVL = 32,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] irq_lines,
  output logic            cpu_irq,
  input  logic            cpu_ack,
  output logic [AW-1:0]   vec_addr,
  input  logic            eoi,
  input  logic            base_we,
  input  logic [AW-1:0]   base_wdata
);
  localparam int LW = $clog2(NLVL);

  logic [NLVL-1:0] isr_q, isr_d, low_oh, allow, elig, set_oh;
  logic [AW-1:0]   base_q;
  logic [LW-1:0]   pend_lvl_q, cand_lvl;
  logic            pend_q, cand_ok, accept;

  assign low_oh = isr_q & (~isr_q + 1'b1);
  assign allow  = low_oh - 1'b1;
  assign elig   = irq_lines & allow;
  assign accept = cpu_ack & pend_q;
  assign set_oh = accept ? (NLVL'(1) << pend_lvl_q) : '0;
  assign isr_d  = (eoi ? (isr_q & (isr_q - 1'b1)) : isr_q) | set_oh;
  assign cpu_irq = pend_q;

  always_comb begin
    cand_ok  = 1'b0;
    cand_lvl = '0;
    for (int i = 0; i < NLVL; i++)
      if (elig[i]) begin
        cand_ok  = 1'b1;
        cand_lvl = LW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q      <= '0;
      base_q     <= '0;
      pend_q     <= 1'b0;
      pend_lvl_q <= '0;
      vec_addr   <= '0;
    end else begin
      isr_q <= isr_d;
      if (base_we) base_q <= base_wdata;
      if (accept) begin
        pend_q   <= 1'b0;
        vec_addr <= base_q + AW'({pend_lvl_q, 2'b00});
      end else if (!pend_q && cand_ok) begin
        pend_q     <= 1'b1;
        pend_lvl_q <= cand_lvl;
      end
    end
  end
endmodule

module vec_irq_ctrl_chk #(
  parameter int NLVL = 32,
  parameter int AW   = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_irq,
  input logic                    cpu_ack,
  input logic                    eoi,
  input logic [AW-1:0]           vec_addr,
  input logic [NLVL-1:0]         isr,
  input logic [$clog2(NLVL)-1:0] pend_lvl
);
  logic [NLVL-1:0] lowest, below;
  assign lowest = isr & (~isr + 1'b1);
  assign below  = lowest - 1'b1;

  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq && !cpu_ack |=> cpu_irq);

  a_r4_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ack && cpu_irq) |=> $stable(vec_addr));

  a_r5_presented_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> below[pend_lvl]);

  a_r6_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !(cpu_ack && cpu_irq) && (isr != '0)
      |=> $countones(isr) + 1 == $past($countones(isr)));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NLVL(NLVL), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .eoi(eoi),
  .vec_addr(vec_addr), .isr(isr_q), .pend_lvl(pend_lvl_q)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
  localparam int NLVL = 32;
  localparam int AW   = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NLVL-1:0] irq_lines = '0;
  logic cpu_ack = 1'b0, eoi = 1'b0, base_we = 1'b0;
  logic [AW-1:0] base_wdata = '0;
  logic cpu_irq;
  logic [AW-1:0] vec_addr;

  int checks = 0, errors = 0;

  // bench model of the requirements
  logic [NLVL-1:0] m_isr = '0;
  logic [AW-1:0]   m_base = '0, m_vec = '0;
  logic            m_pend = 1'b0;
  int              m_lvl = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl #(.NLVL(NLVL), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cpu_irq(cpu_irq),
    .cpu_ack(cpu_ack), .vec_addr(vec_addr), .eoi(eoi),
    .base_we(base_we), .base_wdata(base_wdata)
  );

  task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int pick(input logic [NLVL-1:0] ln, input logic [NLVL-1:0] act);
    int low = NLVL;
    int best = -1;
    for (int i = NLVL - 1; i >= 0; i--) if (act[i]) low = i;
    for (int i = 0; i < low; i++) if (ln[i]) best = i;
    return best;
  endfunction

  task automatic step(input logic [NLVL-1:0] ln, input logic ak, input logic ek,
                      input logic we, input logic [AW-1:0] wd);
    logic [NLVL-1:0] nisr;
    int c;
    irq_lines = ln; cpu_ack = ak; eoi = ek; base_we = we; base_wdata = wd;
    @(posedge clk);
    nisr = m_isr;
    if (ek && m_isr != '0)
      for (int i = 0; i < NLVL; i++)
        if (m_isr[i]) begin nisr[i] = 1'b0; break; end
    if (ak && m_pend) begin
      nisr[m_lvl] = 1'b1;
      m_vec  = m_base + AW'(m_lvl * 4);
      m_pend = 1'b0;
    end else if (!m_pend) begin
      c = pick(ln, m_isr);
      if (c >= 0) begin m_pend = 1'b1; m_lvl = c; end
    end
    if (we) m_base = wd;
    m_isr = nisr;
    @(negedge clk);
    chk("R2 R3 R5 irq", AW'(cpu_irq), AW'(m_pend));
    chk("R4 R7 vec", vec_addr, m_vec);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 irq", AW'(cpu_irq), 0);
    chk("R1 vec", vec_addr, 0);
    rst_n = 1'b1;

    step(32'h200, 0, 0, 0, 0);        chk("R2 raise", AW'(cpu_irq), 1);
    step(0, 0, 0, 0, 0);              chk("R3 held", AW'(cpu_irq), 1);
    step(0, 1, 0, 0, 0);              chk("R4 vec", vec_addr, 36);
                                      chk("R4 drop", AW'(cpu_irq), 0);
    step(32'h1000, 0, 0, 0, 0);       chk("R5 above", AW'(cpu_irq), 0);
    step(32'h200, 0, 0, 0, 0);        chk("R5 same", AW'(cpu_irq), 0);
    step(32'h14, 0, 0, 0, 0);         chk("R5 below", AW'(cpu_irq), 1);
    step(0, 1, 0, 0, 0);              chk("R2 highest", vec_addr, 16);
    step(0, 0, 0, 1, 32'h1000);       chk("R7 no change", vec_addr, 16);
    step(32'h8, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);              chk("R7 new base", vec_addr, 32'h100C);
    step(32'h20, 0, 1, 0, 0);         chk("R6 first", AW'(cpu_irq), 0);
    step(32'h20, 0, 0, 0, 0);         chk("R6 still masked", AW'(cpu_irq), 0);
    step(32'h20, 0, 1, 0, 0);
    step(32'h20, 0, 0, 0, 0);         chk("R6 released", AW'(cpu_irq), 1);
    step(0, 1, 0, 0, 0);              chk("R4 vec5", vec_addr, 32'h1014);
    step(0, 1, 0, 0, 0);              chk("R8 idle ack", vec_addr, 32'h1014);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(32'h80000000, 0, 0, 0, 0);   chk("R8 idle eoi", AW'(cpu_irq), 1);
    step(0, 1, 0, 0, 0);              chk("R4 top", vec_addr, 32'h107C);
    step(0, 0, 1, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [NLVL-1:0] ln;
      ln = ($urandom % 4 == 0) ? NLVL'(1) << ($urandom % NLVL)
                               : $urandom & $urandom & $urandom & $urandom;
      step(ln, ($urandom % 3 == 0), ($urandom % 5 == 0),
           ($urandom % 40 == 0), $urandom & 32'hFFFF_FF00);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule